// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read path of a self-timed nonvolatile memory. While the programming engine reports a write cycle in progress, host reads no longer return array contents; they return a status byte built from the last byte written. Software can then find the end of a write cycle in either of two ways, and both work at once. It can read back the location it just wrote until bit 7 stops being the inverse of what it stored. It can also read any location until bit 6 stops alternating.

A read is recognised once, on the first cycle its strobe is high. The returned byte appears on `rd_data` one clock later with a one-cycle `rd_valid` pulse. Every read during busy counts as a status poll, whether or not the engine is actually storing data. Polling may start on any cycle of the write, including the cycle in which busy rises. Once busy falls, reads return the array's true data again.

The block holds a three-state poll FSM. READY means no write cycle is active. BUSY_EVEN means busy with the next poll returning 0 on bit 6. BUSY_ODD means busy with the next poll returning 1 on bit 6. Its transitions are:
- START: READY to BUSY_EVEN when busy rises without a read.
- START_POLL: READY to BUSY_ODD when busy rises in the same cycle as a read.
- FLIP_UP: BUSY_EVEN to BUSY_ODD on a read.
- FLIP_DOWN: BUSY_ODD to BUSY_EVEN on a read.
- DONE: either busy state back to READY when busy falls.

Top module: `wr_status_reporter`

## Requirements
- R1: While reset is held and on the first cycle after it, `rd_valid` is 0 and `rd_data` is 0.
- R2: With `busy` low, a read returns the sampled `arr_data` unchanged on `rd_data`. The byte appears one cycle after the strobe's first high cycle, together with a single-cycle `rd_valid` pulse.
- R3: With `busy` high and `rd_addr` equal to `last_addr`, bit 7 of the returned byte is the inverse of bit 7 of `last_data`.
- R4: With `busy` high, bit 6 of the returned byte follows a fixed sequence over successive reads: 0, 1, 0, 1, and so on. The sequence restarts at 0 on the first read after each rise of `busy`.
- R5: With `busy` high, bits 5..0 of the returned byte equal `last_data[5:0]` at any address. At an address other than `last_addr`, bit 7 equals `last_data[7]`. Bit 6 advances on reads of any address.
- R6: A strobe held high for several cycles produces one `rd_valid` pulse and advances the bit 6 sequence once.
- R7: A read sampled with `busy` low returns true array data on all 8 bits, including a read in the very cycle `busy` falls.
- R8: A read in the same cycle that `busy` rises is treated as a status poll. It returns bit 6 = 0, and the next read returns bit 6 = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Host read strobe, level; one read per assertion |
| rd_addr | input | 15 | Host read address |
| arr_data | input | 8 | Data read from the array |
| busy | input | 1 | Programming engine reports an active write cycle |
| last_addr | input | 15 | Address of the last byte written |
| last_data | input | 8 | Last byte written |
| rd_data | output | 8 | Byte returned to the host |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` as new |

## Verification
Two events can fall in the same cycle. One is the start or end of a write cycle, which moves the poll FSM along START or DONE. The other is a read edge, which moves it along a flip transition. The bench provokes this by changing `busy` and raising `rd_en` on the same falling clock edge. It does this for both a rise of `busy` and a fall of `busy`. A rise must give a status byte with bit 6 = 0, and the next read must give bit 6 = 1. A fall must give plain array data. The scoreboard predicts each result from its own model of the sequence.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;

    // Poll phase of the status FSM
    typedef enum logic [1:0] {
        PH_READY = 2'd0,
        PH_EVEN  = 2'd1,
        PH_ODD   = 2'd2
    } poll_phase_e;

    // Control word from the FSM to the output stage
    typedef struct packed {
        logic show_status;
        logic toggle_val;
    } poll_ctrl_t;

endpackage

// File: rtl/wr_strobe_edge.sv
module wr_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic pulse
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
        end
    end

    // First high cycle of the strobe only
    assign pulse = strobe & ~strobe_q;

endmodule

// File: rtl/wr_poll_fsm.sv
module wr_poll_fsm
    import wr_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       rd_pulse,
    output poll_ctrl_t ctrl
);

    poll_phase_e state_q;
    poll_phase_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_READY: begin
                if (busy) begin
                    state_d = rd_pulse ? PH_ODD : PH_EVEN;   // START_POLL / START
                end
            end
            PH_EVEN: begin
                if (!busy) begin
                    state_d = PH_READY;                      // DONE
                end else if (rd_pulse) begin
                    state_d = PH_ODD;                        // FLIP_UP
                end
            end
            PH_ODD: begin
                if (!busy) begin
                    state_d = PH_READY;                      // DONE
                end else if (rd_pulse) begin
                    state_d = PH_EVEN;                       // FLIP_DOWN
                end
            end
            default: state_d = PH_READY;
        endcase
    end

    // Outputs: the phase a read in this cycle reports
    always_comb begin
        ctrl.show_status = busy;
        ctrl.toggle_val  = 1'b0;
        unique case (state_q)
            PH_READY: ctrl.toggle_val = 1'b0;
            PH_EVEN:  ctrl.toggle_val = 1'b0;
            PH_ODD:   ctrl.toggle_val = 1'b1;
            default:  ctrl.toggle_val = 1'b0;
        endcase
    end

endmodule

// File: rtl/wr_status_mux.sv
module wr_status_mux
    import wr_status_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_pulse,
    input  poll_ctrl_t        ctrl,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [DATA_W-1:0] status_byte;
    logic [DATA_W-1:0] next_byte;
    logic              addr_hit;

    assign addr_hit = (rd_addr == last_addr);

    // Status byte built bit by bit from the last written byte
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            assign status_byte[b] = last_data[b] ^ addr_hit;
        end else if (b == TOGGLE_BIT) begin : g_tgl
            assign status_byte[b] = ctrl.toggle_val;
        end else begin : g_copy
            assign status_byte[b] = last_data[b];
        end
    end

    assign next_byte = ctrl.show_status ? status_byte : arr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_pulse;
            if (rd_pulse) begin
                rd_data <= next_byte;
            end
        end
    end

endmodule

// File: rtl/wr_status_reporter.sv
module wr_status_reporter
    import wr_status_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic       rd_pulse;
    poll_ctrl_t ctrl;

    wr_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_en),
        .pulse  (rd_pulse)
    );

    wr_poll_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .rd_pulse (rd_pulse),
        .ctrl     (ctrl)
    );

    wr_status_mux #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pulse  (rd_pulse),
        .ctrl      (ctrl),
        .rd_addr   (rd_addr),
        .arr_data  (arr_data),
        .last_addr (last_addr),
        .last_data (last_data),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/wr_status_checker.sv
module wr_status_checker #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOGGLE_BIT = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] arr_data,
    input logic              busy,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid
);

    logic en_q;
    logic was_reset;
    logic rd_edge;

    always_ff @(posedge clk) begin
        en_q      <= rst_n ? rd_en : 1'b0;
        was_reset <= ~rst_n;
    end

    assign rd_edge = rd_en & ~en_q;

    // R1: outputs are cleared on the first cycle after reset
    always @(negedge clk) begin
        if (rst_n && was_reset) begin
            assert_reset_clear_R1: assert (!rd_valid && rd_data == '0);
        end
    end

    // R2: idle read passes array data through
    assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_edge && !busy) |=> (rd_valid && rd_data == $past(arr_data)));

    // R6: one pulse per strobe assertion
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R3: inverted poll bit at the last written address
    assert_poll_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_edge && busy && rd_addr == last_addr) |=>
            (rd_data[POLL_BIT] == ~$past(last_data[POLL_BIT])));

    // R5: low bits carry the last written byte during busy
    assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n || was_reset)
        (rd_edge && busy) |=> (rd_data[5:0] == $past(last_data[5:0])));

    // R8: read coinciding with the start of busy reports toggle 0
    assert_start_poll_R8: assert property (@(posedge clk) disable iff (!rst_n || was_reset)
        (rd_edge && $rose(busy)) |=> (rd_data[TOGGLE_BIT] == 1'b0));

endmodule

bind wr_status_reporter wr_status_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .POLL_BIT   (POLL_BIT),
    .TOGGLE_BIT (TOGGLE_BIT)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .arr_data  (arr_data),
    .busy      (busy),
    .last_addr (last_addr),
    .last_data (last_data),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
);

// File: tb/wr_status_reporter_bench.sv
module wr_status_reporter_bench;

    localparam int AW = 15;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int tests = 0;
    int fails = 0;
    logic tgl_model = 1'b0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    wr_status_reporter u_wr_status_reporter (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .arr_data(arr_data), .busy(busy), .last_addr(last_addr),
        .last_data(last_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Change busy; a rise restarts the model's toggle
    task automatic set_busy(input logic b);
        if (b && !busy) tgl_model = 1'b0;
        busy = b;
    endtask

    // Driver: one read, strobe held for 'hold' cycles, expected byte queued
    task automatic do_read(input string tag, input logic [AW-1:0] a,
                           input logic [DW-1:0] arr, input int hold);
        logic [DW-1:0] e;
        rd_addr  = a;
        arr_data = arr;
        rd_en    = 1'b1;
        if (busy) begin
            e    = last_data;
            e[7] = (a == last_addr) ? ~last_data[7] : last_data[7];
            e[6] = tgl_model;
            tgl_model = ~tgl_model;
        end else begin
            e = arr;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int i = 0; i < hold; i++) @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop and compare on every valid pulse
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R6 actual=extra_valid expected=none");
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset data", rd_data, 8'h00);
        check("R1 reset valid", {7'd0, rd_valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {7'd0, rd_valid}, 8'h00);

        // R2 / R7 idle reads
        do_read("R2 idle a5", 15'h0123, 8'hA5, 1);
        do_read("R2 idle 3c", 15'h7FFF, 8'h3C, 1);

        // Collision: busy rises with a read (R8)
        last_addr = 15'h0040;
        last_data = 8'h9B;
        set_busy(1'b1);
        do_read("R8 start poll", 15'h0040, 8'h00, 1);
        do_read("R8 next poll", 15'h0040, 8'h00, 1);
        do_read("R3 poll last addr", 15'h0040, 8'h11, 1);
        do_read("R5 other addr", 15'h0001, 8'h22, 1);
        do_read("R6 held strobe", 15'h0002, 8'h33, 5);
        do_read("R6 after hold", 15'h0040, 8'h44, 1);

        // Collision: busy falls with a read (R7)
        set_busy(1'b0);
        do_read("R7 busy fall", 15'h0040, 8'h5E, 1);

        // New write cycle, busy rises before read (R4 restart)
        last_addr = 15'h1234;
        last_data = 8'h6D;
        set_busy(1'b1);
        @(negedge clk);
        do_read("R4 restart 0", 15'h0000, 8'h00, 1);
        do_read("R4 second 1", 15'h1234, 8'h00, 1);
        do_read("R4 third 0", 15'h1234, 8'h00, 1);
        do_read("R5 bit7 kept", 15'h1235, 8'hFF, 1);
        set_busy(1'b0);
        @(negedge clk);
        do_read("R7 true data", 15'h1234, 8'hC7, 1);

        repeat (3) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R6 actual=%0d pending expected=0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule